// File: doc/BRIEF.md
# Dual-Channel Gain Control Serial Port

This block is a four-wire serial slave that sits next to a two-channel variable-gain amplifier and owns its control state. A host reaches a small register file through the port. The register file holds two 8-bit attenuation codes, a power control byte and a channel control byte. The block turns these into a 7-bit applied gain code and an off flag for each channel. The applied gain in dB is 26 minus 0.25 times the code.

All pins are sampled by a fast system clock through synchronizers. Every access is one 16-bit frame, sent most significant bit first. The host changes the data line while the serial clock is low, and the block captures it on the rising serial clock edge. A write takes effect only when chip select is released after exactly sixteen rising edges. In a read, the block shifts the addressed byte out on the data-out line, changing it on the falling serial clock edges of the second half of the frame. The channel control byte chooses one of two gain routes. In the first, both channels follow attenuation A. In the second, each channel follows its own register. For each channel, a load enable either lets the routed value through or freezes the gain that channel already has.

Top module: `dual_gain_spi`

## Requirements
- R1: A frame is 16 bits, most significant bit first. Bit 15 is the direction (1 = read, 0 = write), bits 14..11 are reserved, bits 10..8 are the address and bits 7..0 are the data.
- R2: A write is committed only when chip select rises after exactly 16 rising serial clock edges, and only if the reserved bits are all 0. A frame with fewer than 16 edges, with more than 16 edges, or with a reserved bit set changes nothing.
- R3: In a read frame, the byte at the frame's address is presented on spi_miso most significant bit first. Each bit is driven at a falling serial clock edge, starting at the falling edge after the 8th rising edge, so the host captures bit 7 at the 9th rising edge.
- R4: spi_miso_en is 0 while chip select is high and 1 while it is low. A disabled output stands for high impedance.
- R5: The reset values, by address, are: 0 = 0x01 (revision, read-only), 1 = 0x21 (identity, read-only), 2 = 0x00 (power), 3 = 0x50 (attenuation A), 4 = 0x50 (attenuation B), 5 = 0x03 (channel control). After reset both applied gains are 80, both off flags are 0 and spi_miso_en is 0.
- R6: Writes to addresses 0, 1, 6 and 7 are ignored, and reads of addresses 6 and 7 return 0x00.
- R7: ch_a_off is the OR of power bits 5 and 3, and ch_b_off is the OR of power bits 4 and 2.
- R8: Channel control bit 2 selects the route. When it is 1, both channels take attenuation A. When it is 0, channel A takes attenuation A and channel B takes attenuation B.
- R9: Channel control bit 1 (channel A) and bit 0 (channel B) are load enables. While a channel's bit is 0, its applied gain holds, even across writes to its attenuation register. While the bit is 1, the applied gain follows the routed register.
- R10: An attenuation code above 80 is applied as 80. The register itself keeps and reads back the raw byte.
- R11: The applied gains update one system clock after the register or control change that affects them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_en | output | 1 | Data-out drive enable (0 = high impedance) |
| gain_a | output | 7 | Applied gain code, channel A (0..80) |
| gain_b | output | 7 | Applied gain code, channel B (0..80) |
| ch_a_off | output | 1 | Channel A power-down |
| ch_b_off | output | 1 | Channel B power-down |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a 16-bit frame with a 3-bit address and an 8-bit data byte, and a gain ceiling of 80. With these values the bench can hit the saturation edge exactly, at codes 79, 80, 81 and 0xFF. It can also send frames one edge short and one edge long of sixteen, and reach both unmapped addresses. The serial clock runs at one sixteenth of the system rate, so every serial edge passes the synchronizers well before the next edge.

// File: rtl/dgain_pkg.sv
// Package: register addresses, reset values and bit positions shared by the
// serial gain control block. Assumes an 8-bit register width.
package dgain_pkg;
    localparam int REG_REV  = 0;
    localparam int REG_ID   = 1;
    localparam int REG_PWR  = 2;
    localparam int REG_ATTA = 3;
    localparam int REG_ATTB = 4;
    localparam int REG_CTL  = 5;

    localparam logic [7:0] RST_REV  = 8'h01;
    localparam logic [7:0] RST_ID   = 8'h21;
    localparam logic [7:0] RST_PWR  = 8'h00;
    localparam logic [7:0] RST_ATT  = 8'h50;
    localparam logic [7:0] RST_CTL  = 8'h03;

    localparam int CTL_SYNC  = 2;
    localparam int CTL_LOADA = 1;
    localparam int CTL_LOADB = 0;

    localparam int PWR_A_HI = 5;
    localparam int PWR_A_LO = 3;
    localparam int PWR_B_HI = 4;
    localparam int PWR_B_LO = 2;
endpackage

// File: rtl/dgain_spi_rx.sv
// Serial frame engine. It synchronizes the pins to clk, shifts in a frame on
// rising serial clock edges and drives read data on falling edges. It issues
// a write pulse when chip select rises after a complete, well-formed frame.
// Assumes the serial clock is at least four times slower than clk.
module dgain_spi_rx #(
    parameter int SYNC_STAGES = 2,
    parameter int FRAME_BITS  = 16,
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_csn,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int CNT_W  = $clog2(FRAME_BITS + 2);
    localparam int RSV_W  = FRAME_BITS - 1 - ADDR_W - DATA_W;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(FRAME_BITS - DATA_W);

    logic [SYNC_STAGES-1:0] csn_q, sclk_q, mosi_q;
    logic                   csn_d, sclk_d;
    logic                   csn_s, sclk_s, mosi_s;
    logic                   sclk_rise, sclk_fall, cs_fall, cs_rise;
    logic [FRAME_BITS-1:0]  rx_q;
    logic [CNT_W-1:0]       cnt_q;
    logic [DATA_W-1:0]      tx_q;
    logic                   frame_ok;

    // Synchronizer chains and one-cycle history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csn_q  <= '1;
            sclk_q <= '0;
            mosi_q <= '0;
            csn_d  <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            csn_q  <= {csn_q[SYNC_STAGES-2:0], spi_csn};
            sclk_q <= {sclk_q[SYNC_STAGES-2:0], spi_sclk};
            mosi_q <= {mosi_q[SYNC_STAGES-2:0], spi_mosi};
            csn_d  <= csn_s;
            sclk_d <= sclk_s;
        end
    end

    assign csn_s     = csn_q[SYNC_STAGES-1];
    assign sclk_s    = sclk_q[SYNC_STAGES-1];
    assign mosi_s    = mosi_q[SYNC_STAGES-1];
    assign sclk_rise = sclk_s & ~sclk_d & ~csn_s;
    assign sclk_fall = ~sclk_s & sclk_d & ~csn_s;
    assign cs_fall   = ~csn_s & csn_d;
    assign cs_rise   = csn_s & ~csn_d;

    // Shift in frame bits, count edges (saturating past full), drive read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q  <= '0;
            cnt_q <= '0;
            tx_q  <= '0;
        end else if (cs_fall) begin
            cnt_q <= '0;
            tx_q  <= '0;
        end else if (sclk_rise) begin
            rx_q <= {rx_q[FRAME_BITS-2:0], mosi_s};
            if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
        end else if (sclk_fall) begin
            if (cnt_q == CNT_HDR)
                tx_q <= rx_q[DATA_W-1] ? rd_data : '0;
            else if (cnt_q > CNT_HDR && cnt_q < CNT_FULL)
                tx_q <= {tx_q[DATA_W-2:0], 1'b0};
        end
    end

    assign rd_addr  = rx_q[ADDR_W-1:0];
    assign frame_ok = (cnt_q == CNT_FULL) && !rx_q[FRAME_BITS-1]
                      && (rx_q[FRAME_BITS-2 -: RSV_W] == '0);

    // Register the commit pulse and its payload at chip-select release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en   <= cs_rise && frame_ok;
            wr_addr <= rx_q[DATA_W +: ADDR_W];
            wr_data <= rx_q[DATA_W-1:0];
        end
    end

    assign spi_miso    = tx_q[DATA_W-1];
    assign spi_miso_en = ~csn_s;
endmodule

// File: rtl/dgain_regs.sv
// Register file: two read-only identity bytes, power, two attenuation codes and
// channel control. Writes to read-only or unmapped addresses are dropped, and
// unmapped reads return zero. Assumes DATA_W = 8 to match the package values.
module dgain_regs #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] att_a,
    output logic [DATA_W-1:0] att_b,
    output logic              sync_mode,
    output logic              load_a,
    output logic              load_b,
    output logic              off_a,
    output logic              off_b
);
    import dgain_pkg::*;

    logic [DATA_W-1:0] pwr_q, atta_q, attb_q, ctl_q;

    // Writable registers, updated on a commit pulse to a matching address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q  <= RST_PWR;
            atta_q <= RST_ATT;
            attb_q <= RST_ATT;
            ctl_q  <= RST_CTL;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(REG_PWR))  pwr_q  <= wr_data;
            if (wr_addr == ADDR_W'(REG_ATTA)) atta_q <= wr_data;
            if (wr_addr == ADDR_W'(REG_ATTB)) attb_q <= wr_data;
            if (wr_addr == ADDR_W'(REG_CTL))  ctl_q  <= wr_data;
        end
    end

    // Read-back multiplexer.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(REG_REV))  rd_data = RST_REV;
        if (rd_addr == ADDR_W'(REG_ID))   rd_data = RST_ID;
        if (rd_addr == ADDR_W'(REG_PWR))  rd_data = pwr_q;
        if (rd_addr == ADDR_W'(REG_ATTA)) rd_data = atta_q;
        if (rd_addr == ADDR_W'(REG_ATTB)) rd_data = attb_q;
        if (rd_addr == ADDR_W'(REG_CTL))  rd_data = ctl_q;
    end

    assign att_a     = atta_q;
    assign att_b     = attb_q;
    assign sync_mode = ctl_q[CTL_SYNC];
    assign load_a    = ctl_q[CTL_LOADA];
    assign load_b    = ctl_q[CTL_LOADB];
    assign off_a     = pwr_q[PWR_A_HI] | pwr_q[PWR_A_LO];
    assign off_b     = pwr_q[PWR_B_HI] | pwr_q[PWR_B_LO];
endmodule

// File: rtl/dgain_apply.sv
// One channel's applied-gain stage. While load is high it tracks the routed
// code, saturated to GAIN_MAX; while load is low it holds its last value.
// Assumes GAIN_MAX fits in GAIN_W bits.
module dgain_apply #(
    parameter int DATA_W   = 8,
    parameter int GAIN_MAX = 80,
    parameter int GAIN_W   = $clog2(GAIN_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] code,
    output logic [GAIN_W-1:0] gain
);
    localparam logic [DATA_W-1:0] LIMIT = DATA_W'(GAIN_MAX);

    logic [GAIN_W-1:0] sat_code;

    // Clamp the raw code to the top of the gain range.
    always_comb sat_code = (code > LIMIT) ? GAIN_W'(GAIN_MAX) : code[GAIN_W-1:0];

    // Applied gain register with load gating.
    always_ff @(posedge clk) begin
        if (!rst_n)    gain <= GAIN_W'(GAIN_MAX);
        else if (load) gain <= sat_code;
    end
endmodule

// File: rtl/dual_gain_spi.sv
// Top level: serial frame engine, register file and two applied-gain stages.
// The channel-control route picks attenuation A or B as channel B's source.
// Assumes one free-running system clock and a synchronous active-low reset.
module dual_gain_spi #(
    parameter int SYNC_STAGES = 2,
    parameter int FRAME_BITS  = 16,
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 8,
    parameter int GAIN_MAX    = 80,
    parameter int GAIN_W      = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_csn,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_en,
    output logic [GAIN_W-1:0] gain_a,
    output logic [GAIN_W-1:0] gain_b,
    output logic              ch_a_off,
    output logic              ch_b_off
);
    localparam int NUM_CH = 2;

    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data, att_a, att_b;
    logic              wr_en, sync_mode, load_a, load_b;
    logic [DATA_W-1:0] ch_code [NUM_CH];
    logic              ch_load [NUM_CH];
    logic [GAIN_W-1:0] ch_gain [NUM_CH];

    dgain_spi_rx #(
        .SYNC_STAGES(SYNC_STAGES), .FRAME_BITS(FRAME_BITS),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_rx (
        .clk(clk), .rst_n(rst_n),
        .spi_csn(spi_csn), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_miso_en(spi_miso_en),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    dgain_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .att_a(att_a), .att_b(att_b),
        .sync_mode(sync_mode), .load_a(load_a), .load_b(load_b),
        .off_a(ch_a_off), .off_b(ch_b_off)
    );

    // Source routing: channel B follows attenuation A in sync mode.
    always_comb begin
        ch_code[0] = att_a;
        ch_code[1] = sync_mode ? att_a : att_b;
        ch_load[0] = load_a;
        ch_load[1] = load_b;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        dgain_apply #(.DATA_W(DATA_W), .GAIN_MAX(GAIN_MAX), .GAIN_W(GAIN_W)) u_apply (
            .clk(clk), .rst_n(rst_n),
            .load(ch_load[ch]), .code(ch_code[ch]), .gain(ch_gain[ch])
        );
    end

    assign gain_a = ch_gain[0];
    assign gain_b = ch_gain[1];
endmodule

// File: rtl/dgain_checker.sv
// Property checker bound into the top level. It watches the commit pulse, the
// control fields and the applied gains. It only observes.
module dgain_checker #(
    parameter int DATA_W   = 8,
    parameter int GAIN_MAX = 80,
    parameter int GAIN_W   = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] att_a,
    input logic              sync_mode,
    input logic              load_a,
    input logic              load_b,
    input logic [GAIN_W-1:0] gain_a,
    input logic [GAIN_W-1:0] gain_b
);
    assert_gain_ceiling_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_a <= GAIN_W'(GAIN_MAX)) && (gain_b <= GAIN_W'(GAIN_MAX)));

    assert_hold_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_a |=> $stable(gain_a));

    assert_hold_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_b |=> $stable(gain_b));

    assert_sync_equal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && load_a && load_b) |=> (gain_a == gain_b));

    assert_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(att_a));
endmodule

bind dual_gain_spi dgain_checker #(
    .DATA_W(DATA_W), .GAIN_MAX(GAIN_MAX), .GAIN_W(GAIN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .att_a(att_a),
    .sync_mode(sync_mode), .load_a(load_a), .load_b(load_b),
    .gain_a(gain_a), .gain_b(gain_b)
);

// File: tb/test_dual_gain_spi.sv
// Scoreboard bench: the frame driver queues expected read bytes, and a monitor
// pops each one and compares it with the byte captured from spi_miso.
module test_dual_gain_spi;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_csn = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
    logic       spi_miso, spi_miso_en;
    logic [6:0] gain_a, gain_b;
    logic       ch_a_off, ch_b_off;

    int checks = 0;
    int errors = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] got_byte;
    event       frame_done;

    always #2.5 clk = ~clk;

    dual_gain_spi i_dual_gain_spi (
        .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_en(spi_miso_en),
        .gain_a(gain_a), .gain_b(gain_b), .ch_a_off(ch_a_off), .ch_b_off(ch_b_off)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame of nbits edges; bits past 16 are zero. Sends an expected byte
    // to the scoreboard when is_read is set.
    task automatic xfer(input logic [15:0] frame, input int nbits,
                        input bit is_read, input logic [7:0] exp, input string req);
        logic [7:0] cap = '0;
        @(negedge clk);
        spi_csn = 1'b0;
        wait_clk(HALF);
        check("R4", int'(spi_miso_en), 1, "enable during frame");
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = (i < 16) ? frame[15-i] : 1'b0;
            wait_clk(HALF);
            if (i >= 8 && i < 16) cap = {cap[6:0], spi_miso};
            spi_sclk = 1'b1;
            wait_clk(HALF);
            spi_sclk = 1'b0;
        end
        wait_clk(HALF);
        spi_csn = 1'b1;
        wait_clk(HALF);
        if (is_read) begin
            exp_q.push_back(exp);
            tag_q.push_back(req);
            got_byte = cap;
            -> frame_done;
        end
    endtask

    task automatic wr(input int addr, input logic [7:0] d);
        xfer({1'b0, 4'b0, 3'(addr), d}, 16, 1'b0, 8'h00, "");
    endtask

    task automatic rd(input int addr, input logic [7:0] exp, input string req);
        xfer({1'b1, 4'b0, 3'(addr), 8'h00}, 16, 1'b1, exp, req);
    endtask

    // Monitor: compare each captured read byte with the queued expectation.
    initial begin
        forever begin
            @(frame_done);
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R3 unexpected read: actual=%0h expected=none", got_byte);
            end else begin
                check(tag_q.pop_front(), int'(got_byte), int'(exp_q.pop_front()), "read byte");
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        // R5 reset state
        check("R5", int'(gain_a), 80, "gain_a reset");
        check("R5", int'(gain_b), 80, "gain_b reset");
        check("R5", int'(ch_a_off), 0, "off_a reset");
        check("R5", int'(ch_b_off), 0, "off_b reset");
        check("R4", int'(spi_miso_en), 0, "enable idle");
        rd(0, 8'h01, "R5");
        rd(1, 8'h21, "R5");
        rd(2, 8'h00, "R5");
        rd(4, 8'h50, "R5");
        rd(5, 8'h03, "R3");

        // R1 frame layout, R11 update after commit
        wr(3, 8'h10);
        wait_clk(6);
        check("R11", int'(gain_a), 16, "gain_a after write");
        check("R1", int'(gain_b), 80, "gain_b untouched");
        rd(3, 8'h10, "R1");

        // R6 read-only and unmapped
        wr(0, 8'h55);
        rd(0, 8'h01, "R6");
        wr(6, 8'h77);
        rd(6, 8'h00, "R6");
        rd(7, 8'h00, "R6");

        // R2 malformed frames
        xfer({1'b0, 4'b0, 3'd3, 8'h20}, 12, 1'b0, 8'h00, "");
        xfer({1'b0, 4'b0, 3'd3, 8'h20}, 17, 1'b0, 8'h00, "");
        xfer({1'b0, 4'b0100, 3'd3, 8'h20}, 16, 1'b0, 8'h00, "");
        wait_clk(4);
        check("R2", int'(gain_a), 16, "gain_a after bad frames");
        rd(3, 8'h10, "R2");

        // R7 power bits
        wr(2, 8'h20); wait_clk(4);
        check("R7", int'({ch_a_off, ch_b_off}), 2, "pwr 0x20");
        wr(2, 8'h04); wait_clk(4);
        check("R7", int'({ch_a_off, ch_b_off}), 1, "pwr 0x04");
        wr(2, 8'h08); wait_clk(4);
        check("R7", int'({ch_a_off, ch_b_off}), 2, "pwr 0x08");
        wr(2, 8'h10); wait_clk(4);
        check("R7", int'({ch_a_off, ch_b_off}), 1, "pwr 0x10");
        wr(2, 8'hC3); wait_clk(4);
        check("R7", int'({ch_a_off, ch_b_off}), 0, "pwr 0xC3");

        // R8 sync route
        wr(5, 8'h07); wait_clk(4);
        check("R8", int'(gain_b), 16, "gain_b follows A");
        wr(3, 8'h28); wait_clk(4);
        check("R8", int'(gain_a), 40, "gain_a sync");
        check("R8", int'(gain_b), 40, "gain_b sync");

        // R9 load enables
        wr(5, 8'h01); wait_clk(4);
        check("R9", int'(gain_b), 80, "gain_b own reg");
        wr(3, 8'h30); wait_clk(4);
        check("R9", int'(gain_a), 40, "gain_a held");
        wr(4, 8'h08); wait_clk(4);
        check("R9", int'(gain_b), 8, "gain_b loads");
        wr(5, 8'h02); wr(4, 8'h0C); wait_clk(4);
        check("R9", int'(gain_b), 8, "gain_b held");
        check("R9", int'(gain_a), 48, "gain_a loads held value");

        // R10 saturation
        wr(5, 8'h03);
        wr(3, 8'h4F); wait_clk(4);
        check("R10", int'(gain_a), 79, "code 79");
        wr(3, 8'h50); wait_clk(4);
        check("R10", int'(gain_a), 80, "code 80");
        wr(3, 8'h51); wait_clk(4);
        check("R10", int'(gain_a), 80, "code 81");
        wr(3, 8'hFF); wait_clk(4);
        check("R10", int'(gain_a), 80, "code 255");
        rd(3, 8'hFF, "R10");
        check("R10", int'(gain_b), 12, "gain_b 0x0C");

        wait_clk(20);
        check("R3", exp_q.size(), 0, "scoreboard drained");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule